// File: doc/BRIEF.md
# Buffered Down-Counting PWM Channel

This block is a single pulse-width-modulation timer channel of a multi-channel timer. A down counter steps once per tick enable from a shared prescaler. Software writes a period value and a compare value into two buffer registers. These values only reach the live counter and comparator on a manual-update pulse, or when the counter reloads itself at the end of a period. This lets software change the period or duty without glitching the waveform in progress.

The channel takes its start, update, invert and reload controls from a control word that all channels share. It picks out its own bit group using a remapped slot layout:
- Channel 0 sits in slot 0.
- Every later channel sits one slot further up, so slot 1 is left unused.
- The highest channel keeps its reload bit where the other channels keep their invert bit, and it has no inverter.

The channel drives one PWM pin and a one-cycle pulse each time a period completes.

Top module: `pwm_buf_channel`

## Requirements
- R1: After reset both buffers, the counter and the compare register are zero. The channel is idle, the pin sits at the level set by the invert control, and no period-complete pulse is produced.
- R2: A write stores into the period buffer when the byte address equals 12 + 12·CH_IDX, and into the compare buffer when it equals 16 + 12·CH_IDX. A write to any other address leaves both buffers unchanged.
- R3: Writing a buffer changes neither the active counter nor the pin until a manual update or a reload copies the buffer in.
- R4: The control word has 4 bits per slot. Channel 0 uses slot 0, and channel c > 0 uses slot c + 1. Within the slot, bit +0 is start, +1 is manual update, +2 is invert and +3 is reload. The highest channel (NUM_CH−1) is the exception: its reload bit is at +2, it has no invert bit, and its bit +3 is ignored. Bits of other slots, including slot 1, have no effect on the channel.
- R5: While manual update is high, both buffers are copied into the counter and compare register, and the channel is armed. Update takes precedence over counting.
- R6: An armed, started channel decrements once per cycle with tick high, and holds its count when tick is low. A period therefore lasts (period buffer + 1) ticks.
- R7: When the counter is at zero on a tick, the period ends. With reload set, the counter and compare register are reloaded from the buffers. With reload clear, the channel disarms and the pin stays at its inactive level until the next manual update.
- R8: The non-inverted pin is high while the count is less than or equal to the compare value. This gives min(compare, period)+1 high ticks per period, so an all-ones compare value gives 100 % duty.
- R9: The invert control complements the pin.
- R10: With start low, the counter holds its value and the pin takes its inactive level (the invert control value). Setting start again resumes counting.
- R11: Each period end produces exactly one period-complete pulse, one cycle long, in the cycle after the expiring tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable from the prescaler |
| ctl_word_i | input | 4·(NUM_CH+1) | Shared control word for all channels |
| wr_en_i | input | 1 | Buffer write strobe |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_data_i | input | CNT_W | Write data |
| pwm_o | output | 1 | PWM pin |
| period_done_o | output | 1 | One-cycle period-complete pulse |

## Verification
The bench builds three copies with NUM_CH = 5 and an 8-bit counter, at CH_IDX 0, 2 and 4, and drives them all from one control word. This covers the slot-0 layout, the slot shift past the gap, and the moved reload bit of the highest channel. It also lets the bench show that writes and control bits aimed at one channel leave the others alone. The 8-bit counter makes the all-ones compare value (255) and long stopped intervals cheap to reach. Random period and compare pairs are mixed with sparse ticks and directed cases for stopping, pausing and inversion.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  typedef struct packed {
    logic start;
    logic upd;
    logic inv;
    logic arl;
  } chan_ctl_t;

  // slot 1 is left empty: channel 0 -> slot 0, channel c -> slot c+1
  function automatic int unsigned ctl_slot(input int unsigned ch);
    return (ch == 0) ? 0 : ch + 1;
  endfunction

endpackage

// File: rtl/pwm_ctl_slice.sv
module pwm_ctl_slice
  import pwm_chan_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CH_IDX = 0,
  localparam int unsigned CTL_W = 4 * (NUM_CH + 1)
) (
  input  logic [CTL_W-1:0] ctl_word_i,
  output chan_ctl_t        ctl_o
);

  localparam int unsigned BASE    = 4 * ctl_slot(CH_IDX);
  localparam bit          IS_LAST = (CH_IDX == NUM_CH - 1);

  logic unused_ctl;
  assign unused_ctl = ^ctl_word_i;

  assign ctl_o.start = ctl_word_i[BASE];
  assign ctl_o.upd   = ctl_word_i[BASE+1];

  generate
    if (IS_LAST) begin : g_last
      assign ctl_o.inv = 1'b0;
      assign ctl_o.arl = ctl_word_i[BASE+2];
    end else begin : g_std
      assign ctl_o.inv = ctl_word_i[BASE+2];
      assign ctl_o.arl = ctl_word_i[BASE+3];
    end
  endgenerate

endmodule

// File: rtl/pwm_shadow_bufs.sv
module pwm_shadow_bufs #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CH_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  cnt_buf_o,
  output logic [CNT_W-1:0]  cmp_buf_o
);

  localparam int unsigned NBUF   = 2;
  localparam int unsigned STRIDE = 12;
  localparam int unsigned BASE   = 12 + STRIDE * CH_IDX;

  logic [CNT_W-1:0] buf_q [NBUF];

  generate
    for (genvar b = 0; b < NBUF; b++) begin : g_buf
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE + 4 * b);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) buf_q[b] <= '0;
        else if (wr_en_i && wr_addr_i == MY_ADDR) buf_q[b] <= wr_data_i;
      end

      a_r2_write_only_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i || wr_addr_i != MY_ADDR) |=> $stable(buf_q[b]));
    end
  endgenerate

  assign cnt_buf_o = buf_q[0];
  assign cmp_buf_o = buf_q[1];

endmodule

// File: rtl/pwm_down_core.sv
module pwm_down_core
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  chan_ctl_t        ctl_i,
  input  logic [CNT_W-1:0] cnt_buf_i,
  input  logic [CNT_W-1:0] cmp_buf_i,
  output logic             pwm_o,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic live_q, done_q;
  logic step, expire, raw_hi;

  assign step   = live_q & ctl_i.start & tick_i & ~ctl_i.upd;
  assign expire = step & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      live_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= expire;
      if (ctl_i.upd) begin
        cnt_q  <= cnt_buf_i;
        cmp_q  <= cmp_buf_i;
        live_q <= 1'b1;
      end else if (expire) begin
        if (ctl_i.arl) begin
          cnt_q <= cnt_buf_i;
          cmp_q <= cmp_buf_i;
        end else begin
          live_q <= 1'b0;
        end
      end else if (step) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // inclusive compare: all-ones compare keeps the output high all period
  assign raw_hi = live_q & (cnt_q <= cmp_q);
  assign pwm_o  = ctl_i.inv ^ (ctl_i.start & raw_hi);
  assign done_o = done_q;

  a_r5_update_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.upd |=> (cnt_q == $past(cnt_buf_i) && cmp_q == $past(cmp_buf_i) && live_q));

  a_r6_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ctl_i.upd) |=> $stable(cnt_q));

  a_r6_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && ctl_i.start && tick_i && !ctl_i.upd && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r7_stop_without_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && ctl_i.start && tick_i && !ctl_i.upd && !ctl_i.arl && cnt_q == '0) |=> !live_q);

  a_r10_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.start && !ctl_i.upd) |=> $stable(cnt_q));

  a_r11_done_follows_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(tick_i && ctl_i.start));

endmodule

// File: rtl/pwm_buf_channel.sv
module pwm_buf_channel
  import pwm_chan_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CH_IDX = 0,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned CTL_W = 4 * (NUM_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CTL_W-1:0]  ctl_word_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic              pwm_o,
  output logic              period_done_o
);

  chan_ctl_t        ctl;
  logic [CNT_W-1:0] cnt_buf, cmp_buf;

  pwm_ctl_slice #(.NUM_CH(NUM_CH), .CH_IDX(CH_IDX)) u_ctl (
    .ctl_word_i(ctl_word_i),
    .ctl_o     (ctl)
  );

  pwm_shadow_bufs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CH_IDX(CH_IDX)) u_bufs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .cnt_buf_o(cnt_buf),
    .cmp_buf_o(cmp_buf)
  );

  pwm_down_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .ctl_i    (ctl),
    .cnt_buf_i(cnt_buf),
    .cmp_buf_i(cmp_buf),
    .pwm_o    (pwm_o),
    .done_o   (period_done_o)
  );

endmodule

// File: tb/pwm_buf_channel_bench.sv
module pwm_buf_channel_bench;
  localparam int NCH = 5, CW = 8, AW = 8, CTLW = 4 * (NCH + 1);

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CTLW-1:0] ctl_w = '0, extra = '0;
  logic [2:0] pin, done;
  int tests = 0, fails = 0, cyc = 0;
  bit sparse = 1'b0;
  bit st[3], ar[3], iv[3], up[3];

  always #5 clk = ~clk;
  always @(negedge clk) begin
    cyc++;
    tick = sparse ? (cyc % 3 == 0) : 1'b1;
  end

  // index i -> channel 2*i
  pwm_buf_channel #(.NUM_CH(NCH), .CH_IDX(0), .CNT_W(CW), .ADDR_W(AW)) u_pwm_buf_channel_c0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ctl_word_i(ctl_w), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pwm_o(pin[0]), .period_done_o(done[0]));
  pwm_buf_channel #(.NUM_CH(NCH), .CH_IDX(2), .CNT_W(CW), .ADDR_W(AW)) u_pwm_buf_channel_c2 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ctl_word_i(ctl_w), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pwm_o(pin[1]), .period_done_o(done[1]));
  pwm_buf_channel #(.NUM_CH(NCH), .CH_IDX(4), .CNT_W(CW), .ADDR_W(AW)) u_pwm_buf_channel (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ctl_word_i(ctl_w), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pwm_o(pin[2]), .period_done_o(done[2]));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R4 layout: slot 0 for ch0, slot ch+1 otherwise; last channel reload at +2
  task automatic apply_ctl();
    logic [CTLW-1:0] w = '0;
    for (int i = 0; i < 3; i++) begin
      int ch = 2 * i;
      int b = (ch == 0) ? 0 : 4 * (ch + 1);
      w[b]   = st[i];
      w[b+1] = up[i];
      if (ch == NCH - 1) w[b+2] = ar[i];
      else begin
        w[b+2] = iv[i];
        w[b+3] = ar[i];
      end
    end
    ctl_w = w | extra;
  endtask

  function automatic int exp_hi(input int n, input int m);
    return ((m < n) ? m : n) + 1;
  endfunction

  task automatic wr(input int ch, input bit is_cmp, input int val);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = AW'(is_cmp ? 16 + 12 * ch : 12 + 12 * ch);
    wr_data = CW'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic upd_pulse(input int i);
    @(negedge clk);
    up[i] = 1'b1;
    apply_ctl();
    @(negedge clk);
    up[i] = 1'b0;
    apply_ctl();
  endtask

  task automatic sync(input int i, input string tag);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done[i] && n < 3000);
    chk({tag, " sync period pulse"}, int'(done[i]), 1);
  endtask

  task automatic meas(input int i, input int len, output int hi, output int dn);
    hi = int'(pin[i]);
    dn = int'(done[i]);
    for (int k = 1; k < len; k++) begin
      @(negedge clk);
      hi += int'(pin[i]);
      dn += int'(done[i]);
    end
  endtask

  task automatic idle(input int i, input int len, output int hi, output int dn);
    hi = 0;
    dn = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      hi += int'(pin[i]);
      dn += int'(done[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int hi, dn, n, m;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R1 reset pins", int'(pin), 0);
    chk("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release pins", int'(pin), 0);

    // R3: buffers written, started, but no update -> nothing happens
    wr(4, 0, 9); wr(4, 1, 3); wr(0, 0, 5); wr(0, 1, 2);
    st[2] = 1; ar[2] = 1; st[0] = 1; ar[0] = 1; apply_ctl();
    idle(2, 30, hi, dn);
    chk("R3 ch4 no pulse before update", dn, 0);
    chk("R3 ch4 pin idle before update", hi, 0);
    idle(0, 5, hi, dn);
    chk("R3 ch0 no pulse before update", dn, 0);

    // R5/R6/R8/R11: update, then one period
    upd_pulse(2);
    sync(2, "R5");
    meas(2, 10, hi, dn);
    chk("R6 R11 ch4 one pulse per 10 cycles", dn, 1);
    chk("R8 ch4 high ticks", hi, 4);
    upd_pulse(0);
    sync(0, "R5");
    meas(0, 6, hi, dn);
    chk("R6 ch0 one pulse per 6 cycles", dn, 1);
    chk("R8 ch0 high ticks", hi, 3);

    // R2: ch0 address write does not touch ch4; R7 reload picks new ch0 buffer
    wr(0, 0, 20);
    upd_pulse(2);
    sync(2, "R2");
    meas(2, 10, hi, dn);
    chk("R2 ch4 period unchanged by ch0 write", dn, 1);
    chk("R2 ch4 duty unchanged", hi, 4);
    sync(0, "R7");
    meas(0, 21, hi, dn);
    chk("R7 ch0 reload uses new period buffer", dn, 1);
    chk("R7 ch0 duty after reload", hi, 3);

    // random + directed duty/period on ch4
    for (int k = 0; k < 10; k++) begin
      n = $urandom_range(40, 1);
      m = $urandom_range(50, 0);
      if (k == 0) begin n = 7; m = 255; end
      if (k == 1) begin n = 12; m = 0; end
      wr(4, 0, n); wr(4, 1, m);
      upd_pulse(2);
      sync(2, "R6");
      meas(2, n + 1, hi, dn);
      chk($sformatf("R6 period n=%0d", n), dn, 1);
      chk($sformatf("R8 duty n=%0d m=%0d", n, m), hi, exp_hi(n, m));
    end

    // R9 invert on ch0
    iv[0] = 1; apply_ctl();
    wr(0, 0, 5); wr(0, 1, 1);
    upd_pulse(0);
    sync(0, "R9");
    meas(0, 6, hi, dn);
    chk("R9 inverted high ticks", hi, 4);

    // R10 stop via start=0: hold, inactive (inverted -> 1)
    st[0] = 0; apply_ctl();
    idle(0, 20, hi, dn);
    chk("R10 no pulse while stopped", dn, 0);
    chk("R10 pin at inactive inverted level", hi, 20);
    st[0] = 1; apply_ctl();
    sync(0, "R10");
    meas(0, 6, hi, dn);
    chk("R10 resumes period", dn, 1);
    chk("R10 resumes duty", hi, 4);
    iv[0] = 0; apply_ctl();

    // R6 sparse ticks
    wr(4, 0, 4); wr(4, 1, 1);
    sparse = 1'b1;
    upd_pulse(2);
    sync(2, "R6");
    meas(2, 15, hi, dn);
    chk("R6 sparse tick period", dn, 1);
    chk("R6 sparse tick duty", hi, 6);
    sparse = 1'b0;

    // R7/R4: last channel reload bit at +2 cleared, +3 (bit 23) set -> stops
    ar[2] = 0; extra = CTLW'(1) << 23; apply_ctl();
    wr(4, 0, 5); wr(4, 1, 5);
    upd_pulse(2);
    sync(2, "R7");
    idle(2, 40, hi, dn);
    chk("R7 R4 stopped without reload: pulses", dn, 0);
    chk("R7 stopped pin inactive", hi, 0);
    extra = '0; apply_ctl();

    // R4 gap slot 1 does not drive ch2
    wr(2, 0, 3); wr(2, 1, 1);
    extra = CTLW'(8'hF0); apply_ctl();
    idle(1, 20, hi, dn);
    chk("R4 gap slot ignored by ch2", dn, 0);
    extra = '0;
    st[1] = 1; ar[1] = 1; apply_ctl();
    upd_pulse(1);
    sync(1, "R4");
    meas(1, 4, hi, dn);
    chk("R4 ch2 slot 3 period", dn, 1);
    chk("R4 ch2 slot 3 duty", hi, 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule